// File: doc/BRIEF.md
# Walsh Sign Sequence Generator

The block walks through one period of a sampled signal and, at each sample, emits the sign of a chosen Walsh function. The period holds a power-of-two number of samples. A counter sweeps the sample index. A bank of square waves of rising frequency is derived from that index. The sign for the requested order is the product of the square waves that the order's binary digits select. The sign is carried as one bit: 0 means +1 and 1 means −1, so a product of signs is an exclusive-or of bits.

A spectrum engine uses it to correlate a sampled waveform against each basis function, or to rebuild a waveform from coefficients. The engine holds the enable high for every sample it wants to consume and presents the order it needs on the same cycle. The block returns the sign for that sample and order one cycle later, together with a flag that marks the first sample of each period. Dropping the enable freezes the sequence where it stands.

Top module: `walsh_gen`

## Requirements
- R1: While reset is asserted and after it is released, before any enabled cycle, `walsh_neg` and `period_start` are both 0 and the next enabled sample is sample index 0.
- R2: Each clock edge with `en` high consumes one sample. The sample index runs 0, 1, … up to 2^IDX_W−1 and then returns to 0.
- R3: `period_start` is 1 exactly when the presented sample has index 0, so it is high once every 2^IDX_W enabled samples.
- R4: Order 0 gives +1 (`walsh_neg` = 0) at every sample.
- R5: For order n at sample k, `walsh_neg` is the parity of the bitwise AND of n with k written in reversed bit order. Bit i of n selects square wave i+1, and square wave j is −1 when bit IDX_W−j of k is 1.
- R6: Order 1 is −1 over the second half of the period. Order 2^(IDX_W−1) changes sign at every sample, starting at +1.
- R7: A clock edge with `en` low changes neither output nor the sample index. The next enabled sample continues the sequence where it stopped.
- R8: The order is taken on the same edge as the sample it applies to. Changing it between samples affects only the samples that follow.
- R9: For any orders a and b, the sign for order a XOR b at a sample equals the product of the signs for a and b at that sample.
- R10: Both outputs appear one clock edge after the enabled edge that consumes the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Consume one sample on this edge |
| order | input | IDX_W | Walsh order for the sample consumed on this edge |
| walsh_neg | output | 1 | Sign of the presented sample: 0 is +1, 1 is −1 |
| period_start | output | 1 | Presented sample is the first of the period |

## Verification
A sample index that drifts or skips shows up first as `period_start` arriving on the wrong enabled sample. It also shows up in the signs for order 2^(IDX_W−1), which flip at every sample, on the very next enabled cycle. A wrong square-wave mapping or bit order in the index reversal is invisible for order 0. It shows up within one period for at least one of the single-bit orders, so the full sweep over all orders exposes it in at most 2^IDX_W samples per order. A stall that leaks shows up as an output that changes on a disabled edge, or as a sequence that resumes one sample off.

// File: rtl/walsh_gen_pkg.sv
package walsh_gen_pkg;

   // sign encoding: product of signs is XOR of encoded bits
   typedef enum logic {
      SGN_POS = 1'b0,
      SGN_NEG = 1'b1
   } wsign_e;

   // reduction structure for the selected-wave product
   typedef enum int {
      RED_FLAT  = 0,
      RED_CHAIN = 1
   } wreduce_e;

   localparam int unsigned MAX_IDX_W = 16;

endpackage

// File: rtl/walsh_idx_counter.sv
module walsh_idx_counter #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             at_first
);

   localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (step) begin
         if (idx_q == IDX_LAST) begin
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign idx      = idx_q;
   assign at_first = (idx_q == '0);

endmodule

// File: rtl/walsh_rad_bank.sv
module walsh_rad_bank #(
   parameter int unsigned IDX_W = 3
) (
   input  logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] wave_neg
);

   // wave_neg[j] carries square wave j+1; wave 0 is constant +1 and is not built.
   // Square wave m halves its period m times, so its sign follows index bit IDX_W-m.
   for (genvar j = 0; j < IDX_W; j++) begin : g_wave
      assign wave_neg[j] = idx[IDX_W-1-j];
   end

endmodule

// File: rtl/walsh_select_xor.sv
module walsh_select_xor
   import walsh_gen_pkg::*;
#(
   parameter int unsigned IDX_W  = 3,
   parameter wreduce_e    REDUCE = RED_FLAT
) (
   input  logic [IDX_W-1:0] order,
   input  logic [IDX_W-1:0] wave_neg,
   output wsign_e           sign
);

   logic [IDX_W-1:0] picked;

   // order bit i picks square wave i+1
   assign picked = order & wave_neg;

   if (REDUCE == RED_FLAT) begin : g_flat
      assign sign = wsign_e'(^picked);
   end else begin : g_chain
      logic [IDX_W:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < IDX_W; i++) begin : g_link
         assign acc[i+1] = acc[i] ^ picked[i];
      end
      assign sign = wsign_e'(acc[IDX_W]);
   end

endmodule

// File: rtl/walsh_gen.sv
module walsh_gen
   import walsh_gen_pkg::*;
#(
   parameter int unsigned IDX_W  = 3,
   parameter wreduce_e    REDUCE = RED_FLAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [IDX_W-1:0] order,
   output logic             walsh_neg,
   output logic             period_start
);

   if (IDX_W < 1 || IDX_W > MAX_IDX_W) begin : g_bad_width
      $error("walsh_gen: IDX_W out of range");
   end
   if (REDUCE != RED_FLAT && REDUCE != RED_CHAIN) begin : g_bad_reduce
      $error("walsh_gen: unknown REDUCE variant");
   end

   logic [IDX_W-1:0] idx;
   logic             at_first;
   logic [IDX_W-1:0] wave_neg;
   wsign_e           sign_c;
   wsign_e           sign_q;
   logic             start_q;

   walsh_idx_counter #(.IDX_W(IDX_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (en),
      .idx      (idx),
      .at_first (at_first)
   );

   walsh_rad_bank #(.IDX_W(IDX_W)) u_bank (
      .idx      (idx),
      .wave_neg (wave_neg)
   );

   walsh_select_xor #(.IDX_W(IDX_W), .REDUCE(REDUCE)) u_sel (
      .order    (order),
      .wave_neg (wave_neg),
      .sign     (sign_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q  <= SGN_POS;
         start_q <= 1'b0;
      end else if (en) begin
         sign_q  <= sign_c;
         start_q <= at_first;
      end
   end

   assign walsh_neg    = (sign_q == SGN_NEG);
   assign period_start = start_q;

endmodule

// File: rtl/walsh_gen_chk.sv
module walsh_gen_chk #(
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [IDX_W-1:0] order,
   input logic             walsh_neg,
   input logic             period_start
);

   logic [IDX_W-1:0] mdl_idx_q;
   logic [IDX_W-1:0] mdl_rev;
   logic             mdl_sign_q;
   logic             mdl_first_q;

   always_comb begin
      for (int b = 0; b < IDX_W; b++) begin
         mdl_rev[b] = mdl_idx_q[IDX_W-1-b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdl_idx_q   <= '0;
         mdl_sign_q  <= 1'b0;
         mdl_first_q <= 1'b0;
      end else if (en) begin
         mdl_idx_q   <= mdl_idx_q + 1'b1;
         mdl_sign_q  <= ^(order & mdl_rev);
         mdl_first_q <= (mdl_idx_q == '0);
      end
   end

   // R5, R8, R10: sign matches the index model one edge after consumption
   a_r5_sign_model: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (walsh_neg == mdl_sign_q));

   // R3: start flag marks index 0 only
   a_r3_start_model: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (period_start == mdl_first_q));

   // R7: disabled edges leave outputs alone
   a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(walsh_neg) && $stable(period_start)));

   // R4: order 0 is always +1
   a_r4_order_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en && order == '0) |=> !walsh_neg);

   // R2: index 0 is followed by index 1, never a repeated start
   a_r2_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
      (en && period_start) |=> !period_start);

endmodule

bind walsh_gen walsh_gen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .order        (order),
   .walsh_neg    (walsh_neg),
   .period_start (period_start)
);

// File: tb/walsh_gen_tb_top.sv
module walsh_gen_tb_top;

   localparam int unsigned IDX_W  = 3;
   localparam int unsigned NSAMP  = 1 << IDX_W;
   localparam time         CLK_PER = 10ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [IDX_W-1:0] order = '0;
   logic             walsh_neg;
   logic             period_start;

   int unsigned n_vec  = 0;
   int unsigned n_bad  = 0;
   int unsigned k_mdl  = 0;
   logic        done   = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   walsh_gen #(.IDX_W(IDX_W)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .order        (order),
      .walsh_neg    (walsh_neg),
      .period_start (period_start)
   );

   function automatic logic exp_sign(input int unsigned n, input int unsigned k);
      logic p = 1'b0;
      for (int i = 0; i < IDX_W; i++) begin
         if (n[i] && k[IDX_W-1-i]) p = ~p;
      end
      return p;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b (sample %0d)", req, act, exp, k_mdl);
      end
   endtask

   // one edge; returns the presented sign
   task automatic step(input logic e, input int unsigned n, output logic got);
      @(negedge clk);
      en    = e;
      order = n[IDX_W-1:0];
      @(posedge clk);
      #1;
      got = walsh_neg;
   endtask

   task automatic sample(input string req, input int unsigned n, output logic got);
      logic g;
      step(1'b1, n, g);
      check(req, g, exp_sign(n, k_mdl));
      check({req, "/start"}, period_start, (k_mdl == 0));
      got   = g;
      k_mdl = (k_mdl + 1) % NSAMP;
   endtask

   task automatic t_reset();
      logic g;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check("R1 in reset", walsh_neg, 1'b0);
      check("R1 in reset start", period_start, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 5, g);
      check("R1 after release", g, 1'b0);
      check("R1 after release start", period_start, 1'b0);
      k_mdl = 0;
      sample("R1 first sample index 0", 7, g);
   endtask

   task automatic t_sweep();
      logic g;
      while (k_mdl != 0) sample("R2 align", 0, g);
      for (int n = 0; n < NSAMP; n++) begin
         for (int k = 0; k < NSAMP; k++) sample("R5 sweep", n, g);
      end
   endtask

   task automatic t_order_zero();
      logic g;
      for (int k = 0; k < 2 * NSAMP; k++) begin
         sample("R4 order0", 0, g);
         check("R4 order0 plus", g, 1'b0);
      end
   endtask

   task automatic t_single_waves();
      logic g;
      while (k_mdl != 0) sample("R2 align", 0, g);
      for (int k = 0; k < NSAMP; k++) begin
         sample("R6 order1", 1, g);
         check("R6 order1 half", g, (k >= NSAMP / 2));
      end
      for (int k = 0; k < NSAMP; k++) begin
         sample("R6 top order", NSAMP / 2, g);
         check("R6 top order alternates", g, k[0]);
      end
   endtask

   task automatic t_stall();
      logic g, held, hs;
      sample("R7 before stall", 3, held);
      hs = period_start;
      for (int s = 0; s < 3; s++) begin
         step(1'b0, (s + 5) % NSAMP, g);
         check("R7 sign held", g, held);
         check("R7 start held", period_start, hs);
      end
      for (int k = 0; k < NSAMP + 2; k++) sample("R7 resume", 6, g);
   endtask

   task automatic t_order_switch();
      logic g;
      for (int k = 0; k < 3 * NSAMP; k++) sample("R8 switch", (k * 5 + 3) % NSAMP, g);
   endtask

   task automatic t_product();
      logic va [NSAMP];
      logic vb [NSAMP];
      logic g;
      int unsigned a = 3, b = 6;
      while (k_mdl != 0) sample("R2 align", 0, g);
      for (int k = 0; k < NSAMP; k++) begin sample("R9 a", a, g); va[k] = g; end
      for (int k = 0; k < NSAMP; k++) begin sample("R9 b", b, g); vb[k] = g; end
      for (int k = 0; k < NSAMP; k++) begin
         sample("R9 ab", a ^ b, g);
         check("R9 product", g, va[k] ^ vb[k]);
      end
   endtask

   task automatic t_wrap();
      logic g;
      int unsigned starts = 0;
      for (int k = 0; k < 3 * NSAMP; k++) begin
         sample("R3 wrap", 2, g);
         if (period_start) starts++;
      end
      check("R3 one start per period", (starts == 3), 1'b1);
   endtask

   initial begin
      #(CLK_PER * 20000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_order_zero();
      t_sweep();
      t_single_waves();
      t_stall();
      t_order_switch();
      t_product();
      t_wrap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule